// File: doc/BRIEF.md
# Multi-Latency Unit Issue Scoreboard

This block is the issue and retirement controller of an in-order, single-issue pipeline. The pipeline has four execution units with different latencies. Decoded instructions arrive on a valid/ready stream. Each one names a target unit, a destination register and two source registers. The block holds the instruction at the head of the stream until three things are true: its operands are no longer awaited, its unit can start a new operation, and a retirement slot is free. It then strobes that unit's issue line.

For every unit the block keeps a reservation line. The line records which retirement slot each in-flight operation owns. When the unit presents its result, the result lands in that slot. The units finish out of order, because a short operation can overtake a long one. Register writes still leave one per cycle in program order.

The ALU, the adder and the multiplier are fully pipelined. The divider is not pipelined: it takes no new operation until the previous one has run its full length. Back-pressure is simple. `in_ready` is a function of the instruction fields and the internal state only, never of `in_valid`. Upstream must keep the fields stable while `in_valid` is high and `in_ready` is low. A transfer happens on every clock edge where both are high.

Top module: `mlu_issue_sb`

## Requirements
- R1: A synchronous reset empties the retirement buffer, clears every register-pending bit and frees the divider. After reset, `in_ready` is 1 for any instruction and `wr_en` and `iss_go` are 0.
- R2: An instruction is taken when `in_valid` and `in_ready` are both 1. In that cycle exactly one bit of `iss_go` is set. The bit index is the unit code: 0 = ALU, 1 = adder, 2 = multiplier, 3 = divider. No bit is set in any other cycle.
- R3: An instruction whose source register belongs to an older instruction that has not yet written back is held. It is taken at the earliest in the cycle after that older write appears on `wr_en`.
- R4: An instruction whose destination register is still awaited from an older instruction is held until the cycle after that older write.
- R5: Two divider operations are issued at least 24 cycles apart. Back to back, the second is taken exactly 24 cycles after the first.
- R6: The ALU, adder and multiplier each take a new operation every cycle. A busy divider does not hold back instructions for other units.
- R7: At most 8 instructions are in flight between issue and writeback. A ninth is held until the oldest one writes back, and it is taken in the cycle after that write.
- R8: Register writes leave on `wr_en`, `wr_addr` and `wr_data`, at most one per cycle. They come in issue order and carry the result the unit returned for that instruction, whatever order the units finished in.
- R9: A unit's result is taken from `cmp_data` in the cycle `L` cycles after its issue cycle, with `cmp_valid` high for that unit. `L` is 1 for the ALU, 4 for the adder, 7 for the multiplier and 24 for the divider. If no older write is pending, the write appears `L`+1 cycles after issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_unit | input | 2 | Target unit code (0 ALU, 1 adder, 2 multiplier, 3 divider) |
| in_dst | input | 5 | Destination register |
| in_src_a | input | 5 | First source register |
| in_src_b | input | 5 | Second source register |
| iss_go | output | 4 | Per-unit issue strobe, one bit per unit code |
| cmp_valid | input | 4 | Per-unit result present |
| cmp_data | input | 128 | Per-unit result, unit u at bits [32u+31:32u] |
| wr_en | output | 1 | Register write this cycle |
| wr_addr | output | 5 | Register written |
| wr_data | output | 32 | Value written |

## Verification
The hardest state to reach is a full retirement buffer whose oldest entry is still unfinished while younger entries have already completed. Only a long divide followed by seven fast operations produces this, and it tests the hold rule and the in-order drain together. The stimulus issues a divide and then a run of independent ALU operations, so the ALU results finish more than a dozen cycles before the divide. A ninth instruction is queued behind them, and its accept cycle is checked against the divide's writeback. A pseudo-random stream with a small register set then adds dense read-after-write and write-after-write stalls, and a queue model checks every write in order.

// File: rtl/mlu_sb_pkg.sv
`timescale 1ns/1ps
package mlu_sb_pkg;
  localparam int NUM_UNITS = 4;

  typedef enum logic [1:0] {
    U_ALU  = 2'd0,
    U_FADD = 2'd1,
    U_MUL  = 2'd2,
    U_DIV  = 2'd3
  } unit_e;

  // cycles from issue to result for each unit code
  function automatic int unit_lat(input int u);
    case (u)
      0:       return 1;
      1:       return 4;
      2:       return 7;
      default: return 24;
    endcase
  endfunction

  // cycles between two issues to the same unit
  function automatic int unit_ii(input int u);
    return (u == 3) ? 24 : 1;
  endfunction
endpackage

// File: rtl/mlu_sb_gate.sv
`timescale 1ns/1ps
// Structural hazard gate: a unit is free again II cycles after a start.
module mlu_sb_gate #(
  parameter int II = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic free
);
  localparam int CW = (II > 1) ? $clog2(II) : 1;

  logic [CW-1:0] cnt;

  assign free = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= CW'(II - 1);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/mlu_sb_resv.sv
`timescale 1ns/1ps
// Reservation line: carries the retirement slot of each in-flight
// operation alongside the unit's pipeline, one stage per cycle.
module mlu_sb_resv #(
  parameter int LAT = 1,
  parameter int TW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  output logic          out_vld,
  output logic [TW-1:0] out_tag
);
  logic [LAT-1:0] stg_v;
  logic [TW-1:0]  stg_t [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v <= '0;
    end else begin
      stg_v[0] <= push;
      for (int k = 1; k < LAT; k++) stg_v[k] <= stg_v[k-1];
    end
  end

  always_ff @(posedge clk) begin
    stg_t[0] <= push_tag;
    for (int k = 1; k < LAT; k++) stg_t[k] <= stg_t[k-1];
  end

  assign out_vld = stg_v[LAT-1];
  assign out_tag = stg_t[LAT-1];
endmodule

// File: rtl/mlu_sb_cbuf.sv
`timescale 1ns/1ps
// Retirement buffer: slots allocated in issue order, filled in any
// order by the units, drained in order one per cycle.
module mlu_sb_cbuf #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int RW    = 5,
  parameter int NU    = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc,
  input  logic [RW-1:0]                 alloc_dst,
  output logic [$clog2(DEPTH)-1:0]      alloc_tag,
  output logic                          full,
  input  logic [NU-1:0]                 done_vld,
  input  logic [NU-1:0][$clog2(DEPTH)-1:0] done_tag,
  input  logic [NU-1:0][DW-1:0]         done_data,
  output logic                          wr_en,
  output logic [RW-1:0]                 wr_addr,
  output logic [DW-1:0]                 wr_data
);
  localparam int TW = $clog2(DEPTH);

  logic [DEPTH-1:0] held;
  logic [DEPTH-1:0] fin;
  logic [RW-1:0]    dst_m [DEPTH];
  logic [DW-1:0]    dat_m [DEPTH];
  logic [TW-1:0]    head, tail;
  logic [TW:0]      cnt;

  assign alloc_tag = tail;
  assign full      = (cnt == (TW+1)'(DEPTH));
  assign wr_en     = held[head] & fin[head];
  assign wr_addr   = dst_m[head];
  assign wr_data   = dat_m[head];

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      fin  <= '0;
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      for (int u = 0; u < NU; u++)
        if (done_vld[u]) fin[done_tag[u]] <= 1'b1;
      if (alloc) begin
        held[tail] <= 1'b1;
        fin[tail]  <= 1'b0;
        tail       <= tail + 1'b1;
      end
      if (wr_en) begin
        held[head] <= 1'b0;
        fin[head]  <= 1'b0;
        head       <= head + 1'b1;
      end
      case ({alloc, wr_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) dst_m[tail] <= alloc_dst;
    for (int u = 0; u < NU; u++)
      if (done_vld[u]) dat_m[done_tag[u]] <= done_data[u];
  end
endmodule

// File: rtl/mlu_issue_sb.sv
`timescale 1ns/1ps
module mlu_issue_sb #(
  parameter int NREG     = 32,
  parameter int DW       = 32,
  parameter int CB_DEPTH = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [1:0]                          in_unit,
  input  logic [$clog2(NREG)-1:0]             in_dst,
  input  logic [$clog2(NREG)-1:0]             in_src_a,
  input  logic [$clog2(NREG)-1:0]             in_src_b,
  output logic [mlu_sb_pkg::NUM_UNITS-1:0]    iss_go,
  input  logic [mlu_sb_pkg::NUM_UNITS-1:0]    cmp_valid,
  input  logic [mlu_sb_pkg::NUM_UNITS*DW-1:0] cmp_data,
  output logic                                wr_en,
  output logic [$clog2(NREG)-1:0]             wr_addr,
  output logic [DW-1:0]                       wr_data
);
  import mlu_sb_pkg::*;

  localparam int NU = NUM_UNITS;
  localparam int RW = $clog2(NREG);
  localparam int TW = $clog2(CB_DEPTH);

  logic [NREG-1:0]          pend;
  logic [NU-1:0]            unit_free;
  logic                     cb_full;
  logic                     fire;
  logic [TW-1:0]            slot;
  logic [NU-1:0]            done_vld;
  logic [NU-1:0][TW-1:0]    done_tag;
  logic [NU-1:0][DW-1:0]    done_data;

  // operands, destination, structure and slot must all be clear
  assign in_ready = !cb_full && !pend[in_src_a] && !pend[in_src_b] &&
                    !pend[in_dst] && unit_free[in_unit];
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      if (fire)  pend[in_dst]  <= 1'b1;
      if (wr_en) pend[wr_addr] <= 1'b0;
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic          line_vld;
    logic [TW-1:0] line_tag;

    assign iss_go[u] = fire && (in_unit == u[1:0]);

    mlu_sb_gate #(.II(unit_ii(u))) u_gate (
      .clk   (clk),
      .rst   (rst),
      .start (iss_go[u]),
      .free  (unit_free[u])
    );

    mlu_sb_resv #(.LAT(unit_lat(u)), .TW(TW)) u_resv (
      .clk      (clk),
      .rst      (rst),
      .push     (iss_go[u]),
      .push_tag (slot),
      .out_vld  (line_vld),
      .out_tag  (line_tag)
    );

    assign done_vld[u]  = line_vld && cmp_valid[u];
    assign done_tag[u]  = line_tag;
    assign done_data[u] = cmp_data[u*DW +: DW];
  end

  mlu_sb_cbuf #(.DEPTH(CB_DEPTH), .DW(DW), .RW(RW), .NU(NU)) u_cbuf (
    .clk       (clk),
    .rst       (rst),
    .alloc     (fire),
    .alloc_dst (in_dst),
    .alloc_tag (slot),
    .full      (cb_full),
    .done_vld  (done_vld),
    .done_tag  (done_tag),
    .done_data (done_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );
endmodule

// File: rtl/mlu_sb_chk.sv
`timescale 1ns/1ps
module mlu_sb_chk #(
  parameter int NU       = 4,
  parameter int CB_DEPTH = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [NU-1:0] iss_go,
  input logic [NU-1:0] cmp_valid,
  input logic          wr_en
);
  logic [7:0] occ;
  logic [5:0] since_div;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ       <= '0;
      since_div <= 6'd63;
    end else begin
      occ <= occ + 8'((|iss_go) ? 1 : 0) - 8'(wr_en ? 1 : 0);
      if (iss_go[3])              since_div <= '0;
      else if (since_div != 6'd63) since_div <= since_div + 1'b1;
    end
  end

  p_onehot_issue_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(iss_go));
  p_go_needs_hs_r2: assert property (@(posedge clk) disable iff (rst)
    (|iss_go) |-> (in_valid && in_ready));
  p_div_gap_r5: assert property (@(posedge clk) disable iff (rst)
    iss_go[3] |-> (since_div >= 6'd23));
  p_occ_bound_r7: assert property (@(posedge clk) disable iff (rst)
    occ <= 8'(CB_DEPTH));
  p_full_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (occ == 8'(CB_DEPTH)) |-> !in_ready);
  p_write_has_entry_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (occ != 8'd0));
  p_alu_on_time_r9: assert property (@(posedge clk) disable iff (rst)
    cmp_valid[0] |-> $past(iss_go[0]));
  p_fadd_on_time_r9: assert property (@(posedge clk) disable iff (rst)
    cmp_valid[1] |-> $past(iss_go[1], 4));
endmodule

bind mlu_issue_sb mlu_sb_chk #(.NU(mlu_sb_pkg::NUM_UNITS), .CB_DEPTH(CB_DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .iss_go    (iss_go),
  .cmp_valid (cmp_valid),
  .wr_en     (wr_en)
);

// File: tb/tb_mlu_issue_sb.sv
`timescale 1ns/1ps
module tb_mlu_issue_sb;
  localparam int PERIOD = 10;
  localparam int DW = 32;
  localparam int NU = 4;
  localparam int LAT [NU] = '{1, 4, 7, 24};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_unit = '0;
  logic [4:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [NU-1:0] iss_go;
  logic [NU-1:0] cmp_valid = '0;
  logic [NU*DW-1:0] cmp_data = '0;
  logic wr_en;
  logic [4:0] wr_addr;
  logic [DW-1:0] wr_data;

  mlu_issue_sb dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_unit(in_unit), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .iss_go(iss_go), .cmp_valid(cmp_valid), .cmp_data(cmp_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0;
  int fails = 0;
  int lc [32];

  typedef struct { int u; int due; logic [DW-1:0] d; } job_t;
  typedef struct { int r; logic [DW-1:0] d; } wr_t;
  job_t jobs [$];
  wr_t  exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // unit models: return each result exactly L cycles after issue
  always @(negedge clk) begin
    cmp_valid = '0;
    for (int i = jobs.size() - 1; i >= 0; i--) begin
      if (jobs[i].due == cyc) begin
        cmp_valid[jobs[i].u] = 1'b1;
        cmp_data[jobs[i].u*DW +: DW] = jobs[i].d;
        jobs.delete(i);
      end
    end
  end

  // monitor: writes must follow issue order (R8)
  always @(negedge clk) begin
    #1;
    if (!rst && wr_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected write addr", int'(wr_addr), -1);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        chk(int'(wr_addr) == e.r, "R8", "write addr", int'(wr_addr), e.r);
        chk(wr_data == e.d, "R8", "write data", int'(wr_data), int'(e.d));
      end
      lc[wr_addr] = cyc;
    end
  end

  // driver: present one instruction, wait for acceptance, push expectations
  task automatic send(input int u, input int d, input int a, input int b,
                      input logic [DW-1:0] dat, output int acc);
    bit got = 1'b0;
    while (!got) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_unit  = u[1:0];
      in_dst   = d[4:0];
      in_src_a = a[4:0];
      in_src_b = b[4:0];
      #1;
      if (in_ready) begin
        got = 1'b1;
        acc = cyc;
        exp_q.push_back('{d, dat});
        jobs.push_back('{u, cyc + LAT[u], dat});
        if (iss_go != (4'b1 << u))
          chk(1'b0, "R2", "issue strobe", int'(iss_go), 1 << u);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int a0, a1, a2, a3;
    int b0, b1;
    logic [31:0] lcg;
    for (int i = 0; i < 32; i++) lc[i] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: state after reset
    @(negedge clk);
    in_valid = 1'b0; in_unit = 2'd3; in_dst = 5'd9; in_src_a = 5'd8; in_src_b = 5'd7;
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(wr_en == 1'b0, "R1", "wr_en after reset", int'(wr_en), 0);
    chk(iss_go == '0, "R1", "iss_go without valid (R2)", int'(iss_go), 0);

    // R3: source produced by an ALU op in flight
    send(0, 1, 2, 3, 32'h1111_0001, a0);
    send(0, 4, 1, 3, 32'h1111_0002, a1);
    chk(a1 == a0 + LAT[0] + 2, "R3", "RAW accept cycle", a1 - a0, LAT[0] + 2);
    idle(4);

    // R4: destination still awaited
    send(0, 5, 2, 3, 32'h2222_0001, a0);
    send(0, 5, 3, 2, 32'h2222_0002, a1);
    chk(a1 == a0 + LAT[0] + 2, "R4", "WAW accept cycle", a1 - a0, LAT[0] + 2);
    idle(4);

    // R6 / R9 / R8: pipelined units, out-of-order finish, in-order write
    send(2, 6, 20, 21, 32'h3333_0006, a0);
    send(2, 7, 20, 22, 32'h3333_0007, a1);
    send(1, 8, 21, 22, 32'h3333_0008, a2);
    send(1, 9, 23, 20, 32'h3333_0009, a3);
    chk(a1 == a0 + 1, "R6", "multiplier back to back", a1 - a0, 1);
    chk(a3 == a2 + 1, "R6", "adder back to back", a3 - a2, 1);
    idle(20);
    chk(lc[6] == a0 + LAT[2] + 1, "R9", "multiplier write cycle", lc[6] - a0, LAT[2] + 1);
    chk(lc[8] == lc[7] + 1, "R8", "adder waits for older multiply", lc[8] - lc[7], 1);
    chk(lc[9] == lc[8] + 1, "R8", "second adder write order", lc[9] - lc[8], 1);

    // R5 / R9 / R3: divider spacing and latency
    send(3, 11, 2, 3, 32'h4444_000b, b0);
    send(3, 12, 3, 2, 32'h4444_000c, b1);
    chk(b1 == b0 + 24, "R5", "divider issue gap", b1 - b0, 24);
    send(0, 13, 12, 2, 32'h4444_000d, a0);
    chk(lc[11] == b0 + LAT[3] + 1, "R9", "divider write cycle", lc[11] - b0, LAT[3] + 1);
    chk(a0 == b1 + LAT[3] + 2, "R3", "ALU waits for divide result", a0 - b1, LAT[3] + 2);
    idle(10);

    // R7 / R6 / R8: full buffer behind a long divide
    send(3, 14, 0, 2, 32'h5555_000e, b0);
    for (int k = 0; k < 7; k++) begin
      send(0, 15 + k, 0, 2, 32'h5555_0100 + k, a0);
      if (k == 0) chk(a0 == b0 + 1, "R6", "ALU not blocked by divider", a0 - b0, 1);
    end
    send(0, 22, 0, 2, 32'h5555_0016, a1);
    chk(a1 == b0 + LAT[3] + 2, "R7", "ninth instruction accept", a1 - b0, LAT[3] + 2);
    idle(12);
    chk(lc[15] == lc[14] + 1, "R8", "ALU write after older divide", lc[15] - lc[14], 1);
    chk(lc[21] == lc[14] + 7, "R8", "last ALU write", lc[21] - lc[14], 7);

    // R8: pseudo-random stream with dense dependencies
    lcg = 32'h1234_5678;
    for (int n = 0; n < 60; n++) begin
      int u, d, s1, s2;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      u  = int'(lcg[31:30]);
      d  = int'(lcg[27:24]);
      s1 = int'(lcg[23:20]);
      s2 = int'(lcg[19:16]);
      send(u, d, s1, s2, lcg ^ 32'hA5A5_0000, a0);
    end
    idle(60);
    chk(exp_q.size() == 0, "R8", "all writes drained", exp_q.size(), 0);
    chk(wr_en == 1'b0, "R8", "no write when idle", int'(wr_en), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule